// File: doc/BRIEF.md
# Shared Memory Port Controller with Open-Page Tracking

This block connects two masters, a CPU and a video fetch engine, to a single external memory bus. When the bus is free, a fixed-priority arbiter picks a master, and video wins over the CPU. The winner keeps its grant until its access finishes, so a request that arrives mid-access waits its turn. The top bits of the request address pick one region. Each region has its own chip-select line and its own timing in clock cycles.

One region holds DRAM. For that region the controller keeps a hidden copy of the row (page) that was last opened. If the page of a request matches that copy, the row strobe is skipped and only the column strobe is driven. If the page differs and a page is open, a precharge gap comes first, then a row strobe with the new page bits. The page copy is then updated. A column strobe with the low address bits always ends a DRAM access. Other regions use a plain chip-select window that shows the full address. Each access ends with a one-cycle completion pulse. Read data is held for the master on a shared output.

Top module: `pageMemCtl`

## Requirements
- R1: At most one of gntVid and gntCpu is high in any cycle. A grant rises in the cycle after the request is accepted and stays high up to and including the cycle in which done is high.
- R2: When no access is in progress and both masters request, video is served first and the CPU is served after it.
- R3: A grant is never withdrawn before done. A video request raised during a CPU access waits until that CPU access completes, and is then served.
- R4: Address bits [15:14] give the region number. During the strobe cycles of an access, chipSel equals one-hot of that region (bit index = region number), and chipSel is zero otherwise. Region 0 is DRAM, and rasOut or casOut are only high while chipSel[0] is high.
- R5: A non-DRAM access holds its chip select for the region's cycle count (region 1: 2 cycles, regions 2 and 3: 4 cycles by default). It drives the full 16-bit address on memAddr and never raises rasOut or casOut.
- R6: After reset no page is open, so the first DRAM access raises rasOut with no precharge gap. This holds even if the same page was open before the reset.
- R7: A DRAM access whose page (bits [13:7]) differs from the open page spends PRE_CYC granted cycles with no strobe. It then holds rasOut for RAS_CYC cycles with the page, zero-extended, on memAddr. After that the page counts as open.
- R8: Every DRAM access holds casOut for CAS_CYC cycles with the column (bits [6:0]), zero-extended, on memAddr. A page hit raises no rasOut and has no precharge gap.
- R9: rdData, valid from the done cycle, equals memDataIn as sampled in the last strobe cycle. For a CPU write, memWe is high exactly in the column or plain strobe cycles, with the write data on memWData. Video accesses are reads.
- R10: During and right after reset, all grants, done, chipSel, rasOut, casOut and memWe are low. done is never high in two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuReq | input | 1 | CPU request, held until done while gntCpu |
| cpuAddr | input | 16 | CPU address |
| cpuWe | input | 1 | CPU write enable |
| cpuWData | input | 16 | CPU write data |
| vidReq | input | 1 | Video request, held until done while gntVid |
| vidAddr | input | 16 | Video read address |
| gntCpu | output | 1 | CPU owns the bus |
| gntVid | output | 1 | Video owns the bus |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 16 | Captured read data |
| chipSel | output | 4 | One-hot region select |
| rasOut | output | 1 | Row strobe for the DRAM region |
| casOut | output | 1 | Column strobe for the DRAM region |
| memAddr | output | 16 | Multiplexed memory address |
| memWe | output | 1 | Memory write strobe |
| memWData | output | 16 | Memory write data |
| memDataIn | input | 16 | Memory read data |

## Verification
The assertions check the following on every cycle: the grants are exclusive, a grant is never dropped before done, video is picked whenever the bus is idle, chip selects are one-hot, DRAM strobes appear only with the DRAM chip select, a column strobe follows every row strobe, and done is a single-cycle pulse. Some behaviour depends on history and can only be shown by the bench scenarios. This covers whether the row strobe is skipped or issued (page hits, page misses, a re-reset that forgets the open page) and the exact precharge, row, column and plain cycle counts. It also covers the multiplexed address contents and the data returned from a memory model. That model only gives correct data when the row that was really opened matches the request.

// File: rtl/pageMemPkg.sv
package pageMemPkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE,
    PH_RAS,
    PH_CAS,
    PH_PLAIN,
    PH_FIN
  } phase_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic   latchReq;  // capture the winning request
    logic   takeVid;   // winner is the video master
    logic   loadPage;  // record the opened page
    logic   capture;   // sample read data this cycle
    phase_t phase;     // current bus phase
  } ctlStrobe_t;

endpackage

// File: rtl/pmArbiter.sv
module pmArbiter #(
  parameter int unsigned NUM_MASTERS = 2
) (
  input  logic [NUM_MASTERS-1:0] reqVec,   // index 0 has highest priority
  output logic                   anyReq,
  output logic [NUM_MASTERS-1:0] pickVec
);

  logic [NUM_MASTERS:0] blocked;

  assign blocked[0] = 1'b0;

  for (genvar g = 0; g < NUM_MASTERS; g++) begin : gPrio
    assign pickVec[g]   = reqVec[g] && !blocked[g];
    assign blocked[g+1] = blocked[g] || reqVec[g];
  end

  assign anyReq = blocked[NUM_MASTERS];

endmodule

// File: rtl/pmControl.sv
module pmControl
  import pageMemPkg::*;
#(
  parameter int unsigned REG_W      = 2,
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned PRE_CYC    = 2,
  parameter int unsigned RAS_CYC    = 2,
  parameter int unsigned CAS_CYC    = 3,
  parameter logic [(1<<REG_W)*8-1:0] REGION_CYC = {8'd4, 8'd4, 8'd2, 8'd1}
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             anyReq,
  input  logic             pickVid,
  input  logic [REG_W-1:0] winRegion,
  input  logic             winIsDram,
  input  logic             winHit,
  input  logic             pageOpen,
  output ctlStrobe_t       stb,
  output logic             gntVid,
  output logic             gntCpu,
  output logic             done
);

  localparam logic [CNT_W-1:0] PRE_LOAD = CNT_W'(PRE_CYC - 1);
  localparam logic [CNT_W-1:0] RAS_LOAD = CNT_W'(RAS_CYC - 1);
  localparam logic [CNT_W-1:0] CAS_LOAD = CNT_W'(CAS_CYC - 1);

  phase_t           phase, phaseNx;
  logic [CNT_W-1:0] cnt, cntNx;
  logic             ownerVid, ownerNx;
  logic             cntZero;

  function automatic logic [CNT_W-1:0] plainLoad(input logic [REG_W-1:0] r);
    logic [7:0] cyc;
    cyc = REGION_CYC[r*8 +: 8];
    return CNT_W'(cyc) - CNT_W'(1);
  endfunction

  assign cntZero = (cnt == '0);

  always_comb begin
    phaseNx      = phase;
    cntNx        = cnt;
    ownerNx      = ownerVid;
    stb.latchReq = 1'b0;
    stb.takeVid  = pickVid;
    stb.loadPage = 1'b0;
    stb.capture  = 1'b0;
    stb.phase    = phase;
    if (!cntZero) cntNx = cnt - 1'b1;
    unique case (phase)
      PH_IDLE: begin
        if (anyReq) begin
          stb.latchReq = 1'b1;
          ownerNx      = pickVid;
          if (!winIsDram) begin
            phaseNx = PH_PLAIN;
            cntNx   = plainLoad(winRegion);
          end else if (winHit) begin
            phaseNx = PH_CAS;
            cntNx   = CAS_LOAD;
          end else if (pageOpen) begin
            phaseNx = PH_PRE;
            cntNx   = PRE_LOAD;
          end else begin
            phaseNx = PH_RAS;
            cntNx   = RAS_LOAD;
          end
        end
      end
      PH_PRE: begin
        if (cntZero) begin
          phaseNx = PH_RAS;
          cntNx   = RAS_LOAD;
        end
      end
      PH_RAS: begin
        stb.loadPage = 1'b1;
        if (cntZero) begin
          phaseNx = PH_CAS;
          cntNx   = CAS_LOAD;
        end
      end
      PH_CAS, PH_PLAIN: begin
        if (cntZero) begin
          stb.capture = 1'b1;
          phaseNx     = PH_FIN;
        end
      end
      PH_FIN:  phaseNx = PH_IDLE;
      default: phaseNx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      ownerVid <= 1'b0;
    end else begin
      phase    <= phaseNx;
      cnt      <= cntNx;
      ownerVid <= ownerNx;
    end
  end

  assign gntVid = (phase != PH_IDLE) && ownerVid;
  assign gntCpu = (phase != PH_IDLE) && !ownerVid;
  assign done   = (phase == PH_FIN);

endmodule

// File: rtl/pmDatapath.sv
module pmDatapath
  import pageMemPkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned REG_W       = 2,
  parameter int unsigned COL_W       = 7,
  parameter int unsigned DRAM_REGION = 0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctlStrobe_t             stb,
  input  logic [ADDR_W-1:0]      cpuAddr,
  input  logic                   cpuWe,
  input  logic [DATA_W-1:0]      cpuWData,
  input  logic [ADDR_W-1:0]      vidAddr,
  input  logic [DATA_W-1:0]      memDataIn,
  output logic [REG_W-1:0]       winRegion,
  output logic                   winIsDram,
  output logic                   winHit,
  output logic                   pageOpen,
  output logic [(1<<REG_W)-1:0]  chipSel,
  output logic                   rasOut,
  output logic                   casOut,
  output logic [ADDR_W-1:0]      memAddr,
  output logic                   memWe,
  output logic [DATA_W-1:0]      memWData,
  output logic [DATA_W-1:0]      rdData
);

  localparam int unsigned NUM_REG = 1 << REG_W;
  localparam int unsigned PAGE_W  = ADDR_W - REG_W - COL_W;
  localparam int unsigned PAGE_HI = ADDR_W - REG_W - 1;

  logic [ADDR_W-1:0] selAddr, addrQ;
  logic              selWe, weQ;
  logic [DATA_W-1:0] wDataQ;
  logic [PAGE_W-1:0] pageReg;
  logic              pageValid;
  logic [REG_W-1:0]  curRegion;
  logic              strobing;

  // Winner's request, seen before it is latched
  assign selAddr   = stb.takeVid ? vidAddr : cpuAddr;
  assign selWe     = stb.takeVid ? 1'b0 : cpuWe;
  assign winRegion = selAddr[ADDR_W-1 -: REG_W];
  assign winIsDram = (winRegion == REG_W'(DRAM_REGION));
  assign winHit    = pageValid && (selAddr[PAGE_HI:COL_W] == pageReg);
  assign pageOpen  = pageValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      weQ    <= 1'b0;
      wDataQ <= '0;
    end else if (stb.latchReq) begin
      addrQ  <= selAddr;
      weQ    <= selWe;
      wDataQ <= cpuWData;
    end
  end

  // Open-page tracker
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageReg   <= '0;
      pageValid <= 1'b0;
    end else if (stb.loadPage) begin
      pageReg   <= addrQ[PAGE_HI:COL_W];
      pageValid <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdData <= '0;
    else if (stb.capture) rdData <= memDataIn;
  end

  assign curRegion = addrQ[ADDR_W-1 -: REG_W];
  assign strobing  = (stb.phase == PH_RAS) || (stb.phase == PH_CAS) ||
                     (stb.phase == PH_PLAIN);
  assign rasOut    = (stb.phase == PH_RAS);
  assign casOut    = (stb.phase == PH_CAS);

  for (genvar g = 0; g < NUM_REG; g++) begin : gCs
    assign chipSel[g] = strobing && (curRegion == REG_W'(g));
  end

  always_comb begin
    unique case (stb.phase)
      PH_RAS:   memAddr = {{(ADDR_W-PAGE_W){1'b0}}, addrQ[PAGE_HI:COL_W]};
      PH_CAS:   memAddr = {{(ADDR_W-COL_W){1'b0}}, addrQ[COL_W-1:0]};
      PH_PLAIN: memAddr = addrQ;
      default:  memAddr = '0;
    endcase
  end

  assign memWe    = weQ && ((stb.phase == PH_CAS) || (stb.phase == PH_PLAIN));
  assign memWData = wDataQ;

endmodule

// File: rtl/pageMemCtl.sv
module pageMemCtl
  import pageMemPkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned REG_W       = 2,
  parameter int unsigned COL_W       = 7,
  parameter int unsigned DRAM_REGION = 0,
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned PRE_CYC     = 2,
  parameter int unsigned RAS_CYC     = 2,
  parameter int unsigned CAS_CYC     = 3,
  parameter logic [(1<<REG_W)*8-1:0] REGION_CYC = {8'd4, 8'd4, 8'd2, 8'd1}
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cpuReq,
  input  logic [ADDR_W-1:0]     cpuAddr,
  input  logic                  cpuWe,
  input  logic [DATA_W-1:0]     cpuWData,
  input  logic                  vidReq,
  input  logic [ADDR_W-1:0]     vidAddr,
  output logic                  gntCpu,
  output logic                  gntVid,
  output logic                  done,
  output logic [DATA_W-1:0]     rdData,
  output logic [(1<<REG_W)-1:0] chipSel,
  output logic                  rasOut,
  output logic                  casOut,
  output logic [ADDR_W-1:0]     memAddr,
  output logic                  memWe,
  output logic [DATA_W-1:0]     memWData,
  input  logic [DATA_W-1:0]     memDataIn
);

  ctlStrobe_t       stb;
  logic             anyReq;
  logic [1:0]       pickVec;
  logic [REG_W-1:0] winRegion;
  logic             winIsDram, winHit, pageOpen;

  // Index 0 = video, so video always wins
  pmArbiter #(.NUM_MASTERS(2)) u_arb (
    .reqVec  ({cpuReq, vidReq}),
    .anyReq  (anyReq),
    .pickVec (pickVec)
  );

  pmControl #(
    .REG_W      (REG_W),
    .CNT_W      (CNT_W),
    .PRE_CYC    (PRE_CYC),
    .RAS_CYC    (RAS_CYC),
    .CAS_CYC    (CAS_CYC),
    .REGION_CYC (REGION_CYC)
  ) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .anyReq    (anyReq),
    .pickVid   (pickVec[0]),
    .winRegion (winRegion),
    .winIsDram (winIsDram),
    .winHit    (winHit),
    .pageOpen  (pageOpen),
    .stb       (stb),
    .gntVid    (gntVid),
    .gntCpu    (gntCpu),
    .done      (done)
  );

  pmDatapath #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .REG_W       (REG_W),
    .COL_W       (COL_W),
    .DRAM_REGION (DRAM_REGION)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .cpuAddr   (cpuAddr),
    .cpuWe     (cpuWe),
    .cpuWData  (cpuWData),
    .vidAddr   (vidAddr),
    .memDataIn (memDataIn),
    .winRegion (winRegion),
    .winIsDram (winIsDram),
    .winHit    (winHit),
    .pageOpen  (pageOpen),
    .chipSel   (chipSel),
    .rasOut    (rasOut),
    .casOut    (casOut),
    .memAddr   (memAddr),
    .memWe     (memWe),
    .memWData  (memWData),
    .rdData    (rdData)
  );

endmodule

// File: rtl/pmChecker.sv
module pmChecker #(
  parameter int unsigned REG_W       = 2,
  parameter int unsigned DRAM_REGION = 0
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  vidReq,
  input logic                  gntVid,
  input logic                  gntCpu,
  input logic                  done,
  input logic [(1<<REG_W)-1:0] chipSel,
  input logic                  rasOut,
  input logic                  casOut
);

  AST_GRANT_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({gntVid, gntCpu})); // R1

  AST_DONE_OWNED: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (gntVid || gntCpu)); // R1

  AST_VID_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (vidReq && !gntVid && !gntCpu) |=> gntVid); // R2

  AST_CPU_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (gntCpu && !done) |=> gntCpu); // R3

  AST_VID_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (gntVid && !done) |=> gntVid); // R3

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chipSel)); // R4

  AST_STROBE_DRAM: assert property (@(posedge clk) disable iff (!rstN)
    (rasOut || casOut) |-> chipSel[DRAM_REGION]); // R4

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(rasOut && casOut)); // R7

  AST_CAS_AFTER_RAS: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasOut) |-> casOut); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10

endmodule

bind pageMemCtl pmChecker #(
  .REG_W       (REG_W),
  .DRAM_REGION (DRAM_REGION)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .vidReq  (vidReq),
  .gntVid  (gntVid),
  .gntCpu  (gntCpu),
  .done    (done),
  .chipSel (chipSel),
  .rasOut  (rasOut),
  .casOut  (casOut)
);

// File: tb/pageMemCtl_tb.sv
module pageMemCtl_tb;

  localparam int PRE = 2;
  localparam int RAS = 2;
  localparam int CAS = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuReq = 1'b0, cpuWe = 1'b0, vidReq = 1'b0;
  logic [15:0] cpuAddr = '0, cpuWData = '0, vidAddr = '0;
  logic        gntCpu, gntVid, done, rasOut, casOut, memWe;
  logic [15:0] rdData, memAddr, memWData, memDataIn;
  logic [3:0]  chipSel;
  logic [6:0]  benchRow = '0;

  int nChecks = 0;
  int nFail   = 0;
  int cycles  = 0;
  bit bValid  = 0;
  logic [6:0] bPage = '0;

  always #2 clk = ~clk;

  pageMemCtl u_dut (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuAddr(cpuAddr), .cpuWe(cpuWe),
    .cpuWData(cpuWData), .vidReq(vidReq), .vidAddr(vidAddr), .gntCpu(gntCpu),
    .gntVid(gntVid), .done(done), .rdData(rdData), .chipSel(chipSel),
    .rasOut(rasOut), .casOut(casOut), .memAddr(memAddr), .memWe(memWe),
    .memWData(memWData), .memDataIn(memDataIn)
  );

  function automatic logic [15:0] modelData(input logic [15:0] a);
    return (a * 16'd37) ^ 16'hC3A5;
  endfunction

  function automatic int plainCyc(input logic [1:0] r);
    return (r == 2'd1) ? 2 : 4;
  endfunction

  // Memory model: DRAM data depends on the row actually opened
  always_comb begin
    if (casOut)               memDataIn = modelData({2'b00, benchRow, memAddr[6:0]});
    else if (chipSel != 4'b0) memDataIn = modelData(memAddr);
    else                      memDataIn = 16'h0;
  end

  always @(negedge clk) if (rasOut) benchRow = memAddr[6:0];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual %0d expected below 150000", cycles);
      summary();
    end
  end

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; cpuReq = 1'b0; vidReq = 1'b0;
    bValid = 0;
    repeat (3) @(negedge clk);
    check(!gntCpu && !gntVid && !done, "R10", "grants/done in reset", {gntVid, gntCpu, done}, 0);
    check(chipSel == 0 && !rasOut && !casOut && !memWe, "R10", "strobes in reset",
          {chipSel, rasOut, casOut, memWe}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!gntCpu && !gntVid && chipSel == 0 && !memWe, "R10", "idle after reset",
          {gntVid, gntCpu, chipSel, memWe}, 0);
  endtask

  // Wait for one access, check it against the model, then drop its request
  task automatic serveOne(input bit expVid, input int vidAfter);
    logic [15:0] a, wd;
    logic [1:0]  rgn;
    bit we, hit, rasA, casA, plA, csOk, weOk;
    int expPre, expRas, expCas, expPlain;
    int preC, rasC, casC, plC, n;
    a = expVid ? vidAddr : cpuAddr;
    we = expVid ? 1'b0 : cpuWe;
    wd = cpuWData;
    rgn = a[15:14];
    expPre = 0; expRas = 0; expCas = 0; expPlain = 0;
    if (rgn == 2'd0) begin
      hit = bValid && (bPage == a[13:7]);
      expRas = hit ? 0 : RAS;
      expPre = (!hit && bValid) ? PRE : 0;
      expCas = CAS;
      bValid = 1; bPage = a[13:7];
    end else begin
      expPlain = plainCyc(rgn);
    end
    preC = 0; rasC = 0; casC = 0; plC = 0; n = 0;
    rasA = 1; casA = 1; plA = 1; csOk = 1; weOk = 1;
    do begin
      @(negedge clk);
      n++;
      if (n == vidAfter) vidReq = 1'b1;
      if (rasOut) begin rasC++; rasA &= (memAddr == {9'b0, a[13:7]}); end
      if (casOut) begin casC++; casA &= (memAddr == {9'b0, a[6:0]}); end
      if (chipSel != 0 && !rasOut && !casOut) begin plC++; plA &= (memAddr == a); end
      if (chipSel != 0) csOk &= (chipSel == (4'b1 << rgn));
      if ((gntVid || gntCpu) && chipSel == 0 && !done) preC++;
      if (casOut || (chipSel != 0 && !rasOut))
        weOk &= (memWe == we) && (!we || memWData == wd);
      else
        weOk &= !memWe;
    end while (!done && n < 200);
    check(n < 200, "R1", "access completes", n, 0);
    check(gntVid == expVid && gntCpu == !expVid, expVid ? "R2" : "R3", "owner at done",
          {gntVid, gntCpu}, {expVid, !expVid});
    check($onehot({gntVid, gntCpu}), "R1", "single grant with done", {gntVid, gntCpu}, 1);
    check(csOk, "R4", "chip select one-hot of region", chipSel, rgn);
    check(plC == expPlain && plA, "R5", "plain cycles", plC, expPlain);
    check(preC == expPre, expPre == 0 ? "R6" : "R7", "precharge cycles", preC, expPre);
    check(rasC == expRas && rasA, expRas == 0 ? "R8" : "R7", "row strobe cycles", rasC, expRas);
    check(casC == expCas && casA, "R8", "column strobe cycles", casC, expCas);
    check(weOk, "R9", "write strobe/data", we, we);
    check(rdData == modelData(a), "R9", "read data", rdData, modelData(a));
    if (expVid) vidReq = 1'b0; else cpuReq = 1'b0;
  endtask

  task automatic cpuAcc(input logic [15:0] a, input bit w, input logic [15:0] d);
    @(negedge clk);
    cpuAddr = a; cpuWe = w; cpuWData = d; cpuReq = 1'b1;
    serveOne(1'b0, 0);
  endtask

  task automatic vidAcc(input logic [15:0] a);
    @(negedge clk);
    vidAddr = a; vidReq = 1'b1;
    serveOne(1'b1, 0);
  endtask

  function automatic logic [15:0] randAddr();
    logic [1:0] r;
    r = ($urandom % 2 == 0) ? 2'd0 : 2'($urandom % 4);
    return {r, 7'($urandom % 3 + 3), 7'($urandom)};
  endfunction

  initial begin
    void'($urandom(32'd4242));
    doReset();
    // R6: first DRAM access opens page with no precharge
    cpuAcc({2'b00, 7'd3, 7'd5}, 1'b0, 16'h0);
    // R8: page hit, write
    cpuAcc({2'b00, 7'd3, 7'd9}, 1'b1, 16'hBEEF);
    // R7: page miss with page open
    vidAcc({2'b00, 7'd6, 7'd1});
    // R5: plain regions
    cpuAcc({2'b01, 14'h0123}, 1'b1, 16'h1234);
    vidAcc({2'b11, 14'h3ABC});
    // R2: simultaneous requests
    @(negedge clk);
    cpuAddr = {2'b00, 7'd6, 7'd2}; cpuWe = 1'b0; cpuReq = 1'b1;
    vidAddr = {2'b10, 14'h0042}; vidReq = 1'b1;
    serveOne(1'b1, 0);
    serveOne(1'b0, 0);
    // R3: video arrives during a CPU access
    @(negedge clk);
    cpuAddr = {2'b00, 7'd9, 7'd7}; cpuWe = 1'b1; cpuWData = 16'h5A5A; cpuReq = 1'b1;
    vidAddr = {2'b00, 7'd9, 7'd8};
    serveOne(1'b0, 2);
    serveOne(1'b1, 0);
    // R6: reset forgets the open page
    doReset();
    cpuAcc({2'b00, 7'd9, 7'd3}, 1'b0, 16'h0);
    // Random mix
    for (int i = 0; i < 80; i++) begin
      int mode;
      mode = $urandom % 3;
      @(negedge clk);
      cpuAddr = randAddr(); cpuWe = 1'($urandom); cpuWData = 16'($urandom);
      vidAddr = randAddr();
      if (mode == 0) begin cpuReq = 1'b1; serveOne(1'b0, 0); end
      else if (mode == 1) begin vidReq = 1'b1; serveOne(1'b1, 0); end
      else begin cpuReq = 1'b1; vidReq = 1'b1; serveOne(1'b1, 0); serveOne(1'b0, 0); end
    end
    repeat (3) @(negedge clk);
    summary();
  end

endmodule